// File: doc/BRIEF.md
# Receiver Presence Detect and Lane Termination Controller

This block holds, for every lane of a multi-lane serial repeater, the small control machine that decides whether a downstream receiver is attached and what the lane's analog front end should do about it. A detection cycle is armed when the lane's reset control goes from low to high. While the cycle runs the lane holds its input open and its output on the weak pull-up. When a fixed number of clock cycles has passed, the lane samples a comparator that senses the load, stores the answer and pulses a done flag.

The stored answer, the reset and enable controls, the power control and the signal-detect input together choose the termination and driver state. The input side selects between open (high impedance) and a 50-ohm pulldown. The output side selects between open, a weak 2K pull-up (squelch) and a 50-ohm pull-up with the driver on. Separate input-disable and output-disable controls force either side open. All lanes are identical, run independently and share one timeout parameter. The analog sensing is outside the block, which sees only the comparator and signal-detect bits.

Top module: `rxdet_array`

## Requirements
- R1: After the synchronous block reset `rst`, no detection cycle is running, every `det_result` and `det_done` bit is 0, and each lane's terminations follow the rules below with "not detected".
- R2: A detection cycle starts only when a clock edge sees `chan_rst_n` high after it was low at the previous edge, with `pwr_on` and `det_en` both high. A level of `chan_rst_n` held at 0 or at 1 never starts a cycle. A rise while the lane is powered down or has detect disabled starts nothing.
- R3: While a cycle runs, the input termination is high impedance, the output is on the 2K pull-up and the driver is off, whatever `sig_det` is.
- R4: `load_sense` is sampled exactly TIMEOUT clock edges after the edge that saw the rise, and only then. At that edge `det_result` takes the sampled value and `det_done` is high for exactly one cycle.
- R5: With power on, reset high, detect enabled and a completed cycle whose result is 1, the input is the 50-ohm pulldown. The output is the 50-ohm pull-up when `sig_det` is 1 and the 2K pull-up when it is 0. With a result of 0, or with no completed cycle, the input is high impedance and the output is on the 2K pull-up, whatever `sig_det` is.
- R6: With power on, reset high and detect disabled, the input is the 50-ohm pulldown and the output follows `sig_det` as in R5, regardless of the result.
- R7: While `chan_rst_n` is 0 (power on), the input is high impedance and the output is on the 2K pull-up. A running cycle is abandoned and produces no `det_done`.
- R8: While `pwr_on` is 0, both input and output are high impedance, overriding every other control. A cycle in progress or completed is dropped, so after power returns the lane counts as not detected until a new cycle completes. `det_result` keeps its last value.
- R9: `in_dis` = 1 forces the input to high impedance. `out_dis` = 1 forces the output to high impedance with the driver off. Each overrides only its own side.
- R10: Lane i uses `in_term[2i+1:2i]` with 01 = high impedance and 10 = 50-ohm pulldown. It uses `out_term[3i+2:3i]` with 001 = high impedance, 010 = 2K pull-up and 100 = 50-ohm pull-up. `drv_en[i]` is 1 exactly when the output code is 100.
- R11: Lanes are independent: cycles running on several lanes at once produce each lane's own result from its own `load_sense` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| chan_rst_n | input | NUM_CH | Per-lane reset control, low holds the detector; rising edge arms a cycle |
| det_en | input | NUM_CH | Per-lane receiver-detect enable |
| pwr_on | input | NUM_CH | Per-lane power control, 0 = powered down |
| in_dis | input | NUM_CH | Per-lane input disable |
| out_dis | input | NUM_CH | Per-lane output disable |
| load_sense | input | NUM_CH | Per-lane load comparator, 1 = load present |
| sig_det | input | NUM_CH | Per-lane signal detect, 1 = valid input level |
| in_term | output | 2*NUM_CH | One-hot input termination select per lane |
| out_term | output | 3*NUM_CH | One-hot output termination select per lane |
| drv_en | output | NUM_CH | Per-lane output driver enable |
| det_result | output | NUM_CH | Latched detection result per lane |
| det_done | output | NUM_CH | One-cycle pulse when a lane latches its result |

## Verification
Three lanes are armed together with different comparator histories: one steady high, one low until the last cycle before the timeout, and one high until that cycle. These show whether the comparator is sampled only at the timeout edge and whether lanes keep their own results. A fourth lane is raised and dropped mid-cycle, then rearmed, which separates an abort from a completion. Static reset levels and rises on a lane with detect disabled or power off show whether cycles start only on a genuine armed edge. Toggling signal-detect, the disables and power on a detected lane exercises the termination priority.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;

    // One-hot input termination select
    typedef enum logic [1:0] {
        IN_HIZ  = 2'b01,
        IN_PD50 = 2'b10
    } in_term_e;

    // One-hot output termination select
    typedef enum logic [2:0] {
        OUT_HIZ  = 3'b001,
        OUT_PU2K = 3'b010,
        OUT_PU50 = 3'b100
    } out_term_e;

    typedef enum logic [1:0] {
        DET_IDLE = 2'd0,
        DET_RUN  = 2'd1,
        DET_DONE = 2'd2
    } det_state_e;

    // Per-lane control bundle
    typedef struct packed {
        logic chan_rst_n;
        logic det_en;
        logic pwr_on;
        logic in_dis;
        logic out_dis;
        logic sig_det;
    } lane_ctl_t;

    // A lane may start or keep a detection cycle only while all of these hold
    function automatic logic detect_allowed(input lane_ctl_t c);
        return c.pwr_on && c.chan_rst_n && c.det_en;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/rxdet_fsm.sv
module rxdet_fsm
    import rxdet_pkg::*;
#(
    parameter int unsigned TIMEOUT = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  lane_ctl_t  ctl,
    input  logic       load_sense,
    output det_state_e state,
    output logic       result,
    output logic       done
);
    localparam int unsigned CW = cnt_width(TIMEOUT);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic          rst_n_prev;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_n_prev <= 1'b1;
            state      <= DET_IDLE;
            cnt        <= '0;
            result     <= 1'b0;
            done       <= 1'b0;
        end else begin
            rst_n_prev <= ctl.chan_rst_n;
            done       <= 1'b0;
            if (!detect_allowed(ctl)) begin
                state <= DET_IDLE;
                cnt   <= '0;
            end else if (!rst_n_prev) begin
                state <= DET_RUN;
                cnt   <= '0;
            end else if (state == DET_RUN) begin
                if (cnt == LAST) begin
                    result <= load_sense;
                    done   <= 1'b1;
                    state  <= DET_DONE;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rxdet_term_map.sv
module rxdet_term_map
    import rxdet_pkg::*;
(
    input  lane_ctl_t  ctl,
    input  det_state_e state,
    input  logic       result,
    output in_term_e   in_sel,
    output out_term_e  out_sel,
    output logic       drv_en
);
    logic attached;

    always_comb begin
        attached = 1'b0;
        if (ctl.pwr_on && ctl.chan_rst_n) begin
            if (!ctl.det_en) attached = 1'b1;
            else             attached = (state == DET_DONE) && result;
        end

        in_sel  = IN_HIZ;
        out_sel = OUT_PU2K;
        if (!ctl.pwr_on) begin
            out_sel = OUT_HIZ;
        end else if (attached) begin
            in_sel  = IN_PD50;
            out_sel = ctl.sig_det ? OUT_PU50 : OUT_PU2K;
        end

        if (ctl.in_dis)  in_sel  = IN_HIZ;
        if (ctl.out_dis) out_sel = OUT_HIZ;

        drv_en = (out_sel == OUT_PU50);
    end

endmodule

// File: rtl/rxdet_lane.sv
module rxdet_lane
    import rxdet_pkg::*;
#(
    parameter int unsigned TIMEOUT = 256
) (
    input  logic      clk,
    input  logic      rst,
    input  lane_ctl_t ctl,
    input  logic      load_sense,
    output in_term_e  in_sel,
    output out_term_e out_sel,
    output logic      drv_en,
    output logic      result,
    output logic      done
);
    det_state_e state;

    rxdet_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .load_sense (load_sense),
        .state      (state),
        .result     (result),
        .done       (done)
    );

    rxdet_term_map u_map (
        .ctl     (ctl),
        .state   (state),
        .result  (result),
        .in_sel  (in_sel),
        .out_sel (out_sel),
        .drv_en  (drv_en)
    );

endmodule

// File: rtl/rxdet_array.sv
module rxdet_array
    import rxdet_pkg::*;
#(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned TIMEOUT = 256
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CH-1:0]     chan_rst_n,
    input  logic [NUM_CH-1:0]     det_en,
    input  logic [NUM_CH-1:0]     pwr_on,
    input  logic [NUM_CH-1:0]     in_dis,
    input  logic [NUM_CH-1:0]     out_dis,
    input  logic [NUM_CH-1:0]     load_sense,
    input  logic [NUM_CH-1:0]     sig_det,
    output logic [2*NUM_CH-1:0]   in_term,
    output logic [3*NUM_CH-1:0]   out_term,
    output logic [NUM_CH-1:0]     drv_en,
    output logic [NUM_CH-1:0]     det_result,
    output logic [NUM_CH-1:0]     det_done
);
    localparam int unsigned IW = $bits(in_term_e);
    localparam int unsigned OW = $bits(out_term_e);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
        lane_ctl_t ctl;
        in_term_e  in_sel;
        out_term_e out_sel;

        assign ctl = '{chan_rst_n: chan_rst_n[i], det_en: det_en[i],
                       pwr_on: pwr_on[i], in_dis: in_dis[i],
                       out_dis: out_dis[i], sig_det: sig_det[i]};

        rxdet_lane #(.TIMEOUT(TIMEOUT)) u_lane (
            .clk        (clk),
            .rst        (rst),
            .ctl        (ctl),
            .load_sense (load_sense[i]),
            .in_sel     (in_sel),
            .out_sel    (out_sel),
            .drv_en     (drv_en[i]),
            .result     (det_result[i]),
            .done       (det_done[i])
        );

        assign in_term[IW*i +: IW]  = in_sel;
        assign out_term[OW*i +: OW] = out_sel;
    end

endmodule

// File: rtl/rxdet_array_chk.sv
module rxdet_array_chk
    import rxdet_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_CH-1:0]   chan_rst_n,
    input logic [NUM_CH-1:0]   det_en,
    input logic [NUM_CH-1:0]   pwr_on,
    input logic [NUM_CH-1:0]   in_dis,
    input logic [NUM_CH-1:0]   out_dis,
    input logic [NUM_CH-1:0]   load_sense,
    input logic [2*NUM_CH-1:0] in_term,
    input logic [3*NUM_CH-1:0] out_term,
    input logic [NUM_CH-1:0]   drv_en,
    input logic [NUM_CH-1:0]   det_result,
    input logic [NUM_CH-1:0]   det_done
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        logic [1:0] it;
        logic [2:0] ot;
        assign it = in_term[2*g +: 2];
        assign ot = out_term[3*g +: 3];

        a_r10_onehot_codes: assert property (@(posedge clk) disable iff (rst)
            ($countones(it) == 1) && ($countones(ot) == 1));

        a_r10_drv_matches_pu50: assert property (@(posedge clk) disable iff (rst)
            drv_en[g] == (ot == OUT_PU50));

        a_r4_done_single_pulse: assert property (@(posedge clk) disable iff (rst)
            det_done[g] |=> !det_done[g]);

        a_r4_result_is_sample: assert property (@(posedge clk) disable iff (rst)
            det_done[g] |-> det_result[g] == $past(load_sense[g]));

        a_r2_done_needs_enable: assert property (@(posedge clk) disable iff (rst)
            det_done[g] |-> $past(pwr_on[g]) && $past(det_en[g]) && $past(chan_rst_n[g]));

        a_r8_power_off_open: assert property (@(posedge clk) disable iff (rst)
            !pwr_on[g] |-> (it == IN_HIZ) && (ot == OUT_HIZ));

        a_r7_reset_low_weak: assert property (@(posedge clk) disable iff (rst)
            (pwr_on[g] && !chan_rst_n[g] && !out_dis[g]) |-> (ot == OUT_PU2K) && (it == IN_HIZ));

        a_r9_disables: assert property (@(posedge clk) disable iff (rst)
            (in_dis[g] |-> it == IN_HIZ) and (out_dis[g] |-> (ot == OUT_HIZ) && !drv_en[g]));
    end

endmodule

bind rxdet_array rxdet_array_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .chan_rst_n (chan_rst_n),
    .det_en     (det_en),
    .pwr_on     (pwr_on),
    .in_dis     (in_dis),
    .out_dis    (out_dis),
    .load_sense (load_sense),
    .in_term    (in_term),
    .out_term   (out_term),
    .drv_en     (drv_en),
    .det_result (det_result),
    .det_done   (det_done)
);

// File: tb/tb_rxdet_array.sv
module tb_rxdet_array;
    localparam int N  = 8;
    localparam int TO = 8;

    localparam logic [1:0] I_HIZ = 2'b01;
    localparam logic [1:0] I_PD  = 2'b10;
    localparam logic [2:0] O_HIZ = 3'b001;
    localparam logic [2:0] O_2K  = 3'b010;
    localparam logic [2:0] O_50  = 3'b100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0]   chan_rst_n, det_en, pwr_on, in_dis, out_dis, load_sense, sig_det;
    logic [2*N-1:0] in_term;
    logic [3*N-1:0] out_term;
    logic [N-1:0]   drv_en, det_result, det_done;

    always #10 clk = ~clk;

    rxdet_array #(.NUM_CH(N), .TIMEOUT(TO)) dut (
        .clk(clk), .rst(rst), .chan_rst_n(chan_rst_n), .det_en(det_en),
        .pwr_on(pwr_on), .in_dis(in_dis), .out_dis(out_dis),
        .load_sense(load_sense), .sig_det(sig_det), .in_term(in_term),
        .out_term(out_term), .drv_en(drv_en), .det_result(det_result),
        .det_done(det_done)
    );

    typedef struct {
        int         ch;
        logic [1:0] ei;
        logic [2:0] eo;
        logic       er;
        logic       ed;
        string      tag;
    } exp_t;

    exp_t q[$];
    event push_ev;
    int   n_chk  = 0;
    int   n_fail = 0;
    int   done_cnt [N];

    // Done-pulse counters, sampled away from the active edge
    initial for (int i = 0; i < N; i++) done_cnt[i] = 0;
    always @(negedge clk) if (!rst) for (int i = 0; i < N; i++) done_cnt[i] += int'(det_done[i]);

    // Monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(push_ev);
            while (q.size() > 0) begin
                exp_t e;
                logic [1:0] ai;
                logic [2:0] ao;
                e  = q.pop_front();
                ai = in_term[2*e.ch +: 2];
                ao = out_term[3*e.ch +: 3];
                n_chk++;
                if (ai !== e.ei || ao !== e.eo || drv_en[e.ch] !== (e.eo == O_50) ||
                    det_result[e.ch] !== e.er || det_done[e.ch] !== e.ed) begin
                    n_fail++;
                    $display("FAIL %s (R10 codes) lane %0d: in=%b out=%b drv=%b res=%b done=%b expected in=%b out=%b drv=%b res=%b done=%b",
                             e.tag, e.ch, ai, ao, drv_en[e.ch], det_result[e.ch], det_done[e.ch],
                             e.ei, e.eo, (e.eo == O_50), e.er, e.ed);
                end
            end
        end
    end

    task automatic expect_lane(input int ch, input logic [1:0] ei, input logic [2:0] eo,
                               input logic er, input logic ed, input string tag);
        exp_t e;
        e = '{ch: ch, ei: ei, eo: eo, er: er, ed: ed, tag: tag};
        q.push_back(e);
        -> push_ev;
        #1;
    endtask

    task automatic check_cnt(input int ch, input int exp_v, input string tag);
        n_chk++;
        if (done_cnt[ch] != exp_v) begin
            n_fail++;
            $display("FAIL %s lane %0d: done pulses=%0d expected=%0d", tag, ch, done_cnt[ch], exp_v);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        chan_rst_n = '1;
        det_en     = 8'hEF;   // lane 4 detect disabled
        pwr_on     = 8'hDF;   // lane 5 powered down
        in_dis     = '0;
        out_dis    = '0;
        sig_det    = '0;
        load_sense = 8'h45;   // lanes 0, 2, 6 sense a load
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #2;
        // R1: reset state
        expect_lane(0, I_HIZ, O_2K, 1'b0, 1'b0, "R1 reset lane0");
        expect_lane(3, I_HIZ, O_2K, 1'b0, 1'b0, "R1 reset lane3");
        expect_lane(4, I_PD,  O_2K, 1'b0, 1'b0, "R1/R6 reset lane4");
        expect_lane(5, I_HIZ, O_HIZ, 1'b0, 1'b0, "R1/R8 reset lane5");

        // Arm lanes 0..2, and rise lanes 4, 5 where detection is not allowed
        @(negedge clk);
        chan_rst_n[2:0] = 3'b000; chan_rst_n[4] = 1'b0; chan_rst_n[5] = 1'b0;
        sig_det[0] = 1'b1;
        #2 expect_lane(0, I_HIZ, O_2K, 1'b0, 1'b0, "R7 reset low ignores sig_det");
        @(negedge clk);
        chan_rst_n[2:0] = 3'b111; chan_rst_n[4] = 1'b1; chan_rst_n[5] = 1'b1;
        sig_det[2:0] = 3'b111;
        for (int j = 0; j < TO; j++) begin
            @(negedge clk);
            if (j == TO - 1) begin
                load_sense[1] = 1'b1;
                load_sense[2] = 1'b0;
            end
            #2 expect_lane(0, I_HIZ, O_2K, 1'b0, 1'b0, "R3 cycle running");
        end
        @(negedge clk);
        #2;
        expect_lane(0, I_PD,  O_50, 1'b1, 1'b1, "R4 done at timeout, R5 attached");
        expect_lane(1, I_PD,  O_50, 1'b1, 1'b1, "R4 sampled only at timeout");
        expect_lane(2, I_HIZ, O_2K, 1'b0, 1'b1, "R11 own result, R5 no load");
        @(negedge clk);
        sig_det[0] = 1'b0; sig_det[4] = 1'b1; sig_det[5] = 1'b1;
        #2;
        expect_lane(0, I_PD,  O_2K, 1'b1, 1'b0, "R5 squelch on no signal");
        expect_lane(4, I_PD,  O_50, 1'b0, 1'b0, "R6 detect disabled follows sig_det");
        expect_lane(5, I_HIZ, O_HIZ, 1'b0, 1'b0, "R8 powered down");
        check_cnt(4, 0, "R2 rise with detect disabled");
        check_cnt(5, 0, "R2 rise while powered down");

        // R9 disables
        @(negedge clk); sig_det[0] = 1'b1; in_dis[0] = 1'b1;
        #2 expect_lane(0, I_HIZ, O_50, 1'b1, 1'b0, "R9 input disable");
        @(negedge clk); out_dis[0] = 1'b1;
        #2 expect_lane(0, I_HIZ, O_HIZ, 1'b1, 1'b0, "R9 output disable");
        @(negedge clk); in_dis[0] = 1'b0; out_dis[0] = 1'b0;
        #2 expect_lane(0, I_PD, O_50, 1'b1, 1'b0, "R9 disables released");

        // R8 power cycle on a detected lane
        @(negedge clk); pwr_on[1] = 1'b0;
        #2 expect_lane(1, I_HIZ, O_HIZ, 1'b1, 1'b0, "R8 power down detected lane");
        @(negedge clk); pwr_on[1] = 1'b1;
        #2 expect_lane(1, I_HIZ, O_2K, 1'b1, 1'b0, "R8 back to not detected");

        // R7 abort mid-cycle then rearm, lane 6
        @(negedge clk); chan_rst_n[6] = 1'b0;
        @(negedge clk); chan_rst_n[6] = 1'b1;
        repeat (3) @(negedge clk);
        chan_rst_n[6] = 1'b0;
        #2 expect_lane(6, I_HIZ, O_2K, 1'b0, 1'b0, "R7 abort mid-cycle");
        repeat (TO + 2) @(negedge clk);
        #2 check_cnt(6, 0, "R7 aborted cycle gives no done");
        @(negedge clk); chan_rst_n[6] = 1'b1;
        repeat (TO) @(negedge clk);
        #2 expect_lane(6, I_HIZ, O_2K, 1'b0, 1'b0, "R4 not done one edge early");
        @(negedge clk);
        #2 expect_lane(6, I_PD, O_2K, 1'b1, 1'b1, "R4 rearmed cycle completes");

        // R2 static levels
        repeat (TO + 2) @(negedge clk);
        #2;
        check_cnt(0, 1, "R2 static high after cycle, R4 single pulse");
        check_cnt(3, 0, "R2 static high never arms");
        check_cnt(6, 1, "R4 single pulse lane6");
        expect_lane(3, I_HIZ, O_2K, 1'b0, 1'b0, "R2 untouched lane");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule